// File: doc/BRIEF.md
# Signed Radix-4 Booth Multiplier with Constant-Width Rows

This block multiplies two signed N-bit two's complement numbers and returns the full 2N-bit signed product. The multiplier operand is recoded two bits at a time into radix-4 digits in the range -2 to +2. Each digit selects zero, the multiplicand, or twice the multiplicand, optionally inverted. This halves the number of partial-product rows compared with a plain array.

Sign extension of the rows is not carried out. Instead, each row has its top bit inverted and a constant one placed just above it, and a single extra one is placed at column N. Every row is therefore exactly N+2 columns wide, so the array stays rectangular. The "+1" that completes the negation of a negative digit is not added inside the selector. It enters the summation as a separate bit at the row's lowest column.

All rows are reduced by a chain of carry-save stages, and one carry-propagate adder forms the result. A caller presents the operands together with `in_valid`. On the next clock edge the product is captured in a register, and `out_valid` is raised for one cycle.

Top module: `booth_sg_mult`

## Requirements
- R1: When `in_valid` is high at a rising edge, `product` after that edge equals the signed product of `a_in` and `b_in` (two's complement, N bits each), as a 2N-bit two's complement value.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high at the edge, and low otherwise.
- R3: While `in_valid` is low, `product` keeps its last value, whatever `a_in` and `b_in` do.
- R4: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears `out_valid` and `product` to zero.
- R5: Most negative times most negative (-2^(N-1) squared) gives +2^(2N-2) without wrap.
- R6: Most negative times -1 gives +2^(N-1) exactly.
- R7: A zero in either operand gives a product of zero.
- R8: Digit recoding covers all eight multiplier bit triples. A multiplier of all ones (-1) yields the negated multiplicand, and the triples 000 and 111 contribute nothing.
- R9: For nonzero operands, the product's most significant bit equals the XOR of the operand sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid; product captured at this edge |
| a_in | input | N | Multiplicand, two's complement |
| b_in | input | N | Multiplier, two's complement (recoded) |
| out_valid | output | 1 | Product register updated in the previous edge |
| product | output | 2N | Signed product, two's complement |

## Verification
Every fault inside the array appears at `product` in the cycle right after the operands are accepted, because there is only one register stage. A wrong or missing constant-one correction shows up as a fixed power-of-two offset on nearly every product, so ordinary vectors expose it at once. A recoding fault changes only products whose multiplier contains the affected bit triple. For that reason the stimulus mixes random operands with all-ones, most-negative and zero operands, so that every triple and every digit sign is exercised.

// File: rtl/booth_sg_pkg.sv
// Shared types for the radix-4 Booth multiplier.
package booth_sg_pkg;
    // Selection controls decoded from one multiplier bit triple.
    typedef struct packed {
        logic neg;   // invert selected magnitude, add one at row LSB
        logic one;   // select multiplicand
        logic two;   // select multiplicand shifted left by one
    } booth_sel_t;
endpackage

// File: rtl/booth_sg_recode.sv
// Decodes one overlapping triple of multiplier bits into a radix-4 digit.
// Assumes: trip[0] is the bit below the pair (zero for the lowest pair).
// A digit of zero never has neg set, so no stray "+1" enters the array.
module booth_sg_recode
    import booth_sg_pkg::*;
(
    input  logic [2:0]  trip,
    output booth_sel_t  sel
);
    // Digit decode: magnitude 1, magnitude 2, and negative sign.
    always_comb begin
        sel.one = trip[1] ^ trip[0];
        sel.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
        sel.neg = trip[2] & ~(trip[1] & trip[0]);
    end

    // Guard checks on the decoded digit (R8).
    always_comb begin
        if (!$isunknown(trip)) begin
            a_sel_onehot_r8: assert ($onehot0({sel.one, sel.two}));
            a_zero_not_neg_r8: assert (!(sel.neg && !sel.one && !sel.two));
        end
    end
endmodule

// File: rtl/booth_sg_pprow.sv
// Builds one partial-product row, aligned in a 2N-bit vector.
// The sign bit is inverted and a constant one is placed one column above it,
// so the row has a fixed width of N+2 bits before the shift by 2*ROW.
// Assumes: N even and at least 4.
module booth_sg_pprow
    import booth_sg_pkg::*;
#(
    parameter int N   = 16,
    parameter int ROW = 0
) (
    input  logic [N-1:0]   a,
    input  booth_sel_t     sel,
    output logic [2*N-1:0] row_vec
);
    localparam int W  = 2 * N;
    localparam int SH = 2 * ROW;

    logic [N:0]   a_ext;
    logic [N:0]   pp;
    logic [N+1:0] row_bits;

    assign a_ext = {a[N-1], a};

    // One selector per column; column 0 sees a zero below it for the x2 case.
    for (genvar j = 0; j <= N; j++) begin : g_col
        if (j == 0) begin : g_lsb
            assign pp[j] = (sel.one & a_ext[j]) ^ sel.neg;
        end else begin : g_mid
            assign pp[j] = ((sel.one & a_ext[j]) | (sel.two & a_ext[j-1])) ^ sel.neg;
        end
    end

    // Row body: constant one, inverted sign, then the low N bits.
    always_comb begin
        row_bits = {1'b1, ~pp[N], pp[N-1:0]};
        row_vec  = {{(W-N-2){1'b0}}, row_bits} << SH;
    end

    // A zero digit must give a body of zeros with the inverted sign set (R8).
    always_comb begin
        if (!$isunknown({a, sel}) && !sel.one && !sel.two) begin
            a_zero_row_r8: assert (row_bits == {2'b11, {N{1'b0}}});
        end
    end
endmodule

// File: rtl/booth_sg_csa.sv
// Reduces M rows plus one correction vector with a linear chain of M-1
// carry-save stages, then resolves the final pair with one adder.
// All columns above 2N-1 are discarded.
module booth_sg_csa #(
    parameter int N = 16
) (
    input  logic [N/2-1:0][2*N-1:0] rows,
    input  logic [2*N-1:0]          corr,
    output logic [2*N-1:0]          sum
);
    localparam int M = N / 2;
    localparam int W = 2 * N;

    logic [W-1:0] s_lvl [M];
    logic [W-1:0] c_lvl [M];

    // First level: the first row with the correction vector as its carry word.
    assign s_lvl[0] = rows[0];
    assign c_lvl[0] = corr;

    // One 3:2 stage per further row.
    for (genvar k = 1; k < M; k++) begin : g_stage
        logic [W-1:0] maj;
        assign s_lvl[k] = s_lvl[k-1] ^ c_lvl[k-1] ^ rows[k];
        assign maj      = (s_lvl[k-1] & c_lvl[k-1]) | (s_lvl[k-1] & rows[k]) |
                          (c_lvl[k-1] & rows[k]);
        assign c_lvl[k] = {maj[W-2:0], 1'b0};
    end

    // Final carry-propagate addition.
    assign sum = s_lvl[M-1] + c_lvl[M-1];
endmodule

// File: rtl/booth_sg_mult.sv
// Signed N x N radix-4 Booth multiplier with constant-width rows.
// The product register is loaded on the edge that samples in_valid;
// out_valid marks that update for one cycle.
// Assumes: N even, N >= 4; synchronous active-low reset.
module booth_sg_mult
    import booth_sg_pkg::*;
#(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    output logic           out_valid,
    output logic [2*N-1:0] product
);
    localparam int M = N / 2;
    localparam int W = 2 * N;

    logic [N:0]            b_ext;
    booth_sel_t            sel [M];
    logic [M-1:0][W-1:0]   rows;
    logic [W-1:0]          corr;
    logic [W-1:0]          sum;

    assign b_ext = {b_in, 1'b0};

    // One recoder and one row builder per digit.
    for (genvar k = 0; k < M; k++) begin : g_row
        booth_sg_recode u_rec (
            .trip (b_ext[2*k+2:2*k]),
            .sel  (sel[k])
        );
        booth_sg_pprow #(.N(N), .ROW(k)) u_row (
            .a       (a_in),
            .sel     (sel[k]),
            .row_vec (rows[k])
        );
    end

    // Correction word: deferred negation ones at even columns plus a one at column N.
    always_comb begin
        corr    = '0;
        corr[N] = 1'b1;
        for (int k = 0; k < M; k++) begin
            corr[2*k] = sel[k].neg;
        end
    end

    booth_sg_csa #(.N(N)) u_csa (
        .rows (rows),
        .corr (corr),
        .sum  (sum)
    );

    // Output register: reset clears, in_valid loads, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                product <= sum;
            end
        end
    end

    // R2: strobe follows the input strobe by one cycle.
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3: product holds while no operands are accepted.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));
    // R7: a zero operand gives a zero product.
    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_in == '0 || b_in == '0)) |=> (product == '0));
    // R9: result sign follows operand signs for nonzero operands.
    p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_in != '0 && b_in != '0) |=>
        (product[W-1] == ($past(a_in[N-1]) ^ $past(b_in[N-1]))));
endmodule

// File: tb/test_booth_sg_mult.sv
`timescale 1ns/1ps
module test_booth_sg_mult;
    localparam int N = 16;
    localparam int W = 2 * N;
    localparam int NV = 10;

    // Each entry: {a, b, expected product}.
    localparam logic [63:0] VEC [NV] = '{
        {16'hFFB5, 16'h0072, 32'hFFFFDE9A},  // -75 * 114, R1
        {16'h004A, 16'h0069, 32'h00001E5A},  // 74 * 105, R1
        {16'h8000, 16'h8000, 32'h40000000},  // min * min, R5
        {16'h8000, 16'hFFFF, 32'h00008000},  // min * -1, R6
        {16'h0000, 16'h8000, 32'h00000000},  // zero a, R7
        {16'h3039, 16'h0000, 32'h00000000},  // zero b, R7
        {16'h7FFF, 16'h7FFF, 32'h3FFF0001},  // max * max, R1
        {16'hFFFF, 16'hFFFF, 32'h00000001},  // -1 * -1, R8
        {16'h7FFF, 16'h8000, 32'hC0008000},  // max * min, R9
        {16'hFFFF, 16'h022B, 32'hFFFFFDD5}   // -1 * 555, R8
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N-1:0]   a_in = '0;
    logic [N-1:0]   b_in = '0;
    logic           out_valid;
    logic [W-1:0]   product;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    booth_sg_mult #(.N(N)) i_booth_sg_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .out_valid (out_valid),
        .product   (product)
    );

    function automatic string vec_tag(int i);
        case (i)
            2: return "R5";
            3: return "R6";
            4, 5: return "R7";
            7, 9: return "R8";
            8: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one operand pair for one cycle, then check product and strobe.
    task automatic mul_once(logic [N-1:0] a, logic [N-1:0] b, logic [W-1:0] exp, string tag);
        @(negedge clk);
        a_in = a; b_in = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, product, exp);
        check("R2", {{(W-1){1'b0}}, out_valid}, 1);
    endtask

    initial begin
        logic signed [N-1:0] ra, rb;
        logic signed [W-1:0] rp;
        logic [W-1:0]        held;

        // R4: reset state.
        repeat (3) @(negedge clk);
        check("R4", product, '0);
        check("R4", {{(W-1){1'b0}}, out_valid}, 0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            mul_once(VEC[i][63:48], VEC[i][47:32], VEC[i][31:0], vec_tag(i));
        end

        // R3 and R2: change operands without in_valid; output must not move.
        held = product;
        @(negedge clk);
        a_in = 16'h1234; b_in = 16'h5678;
        @(negedge clk);
        check("R3", product, held);
        check("R2", {{(W-1){1'b0}}, out_valid}, 0);

        // R1/R8: random operands against a behavioural signed multiply.
        for (int i = 0; i < 300; i++) begin
            ra = N'($urandom);
            rb = N'($urandom);
            rp = ra * rb;
            mul_once(ra, rb, rp, "R1");
        end

        // R8: multiplier -1 negates each of several multiplicands.
        for (int i = 0; i < 8; i++) begin
            ra = N'($urandom);
            rp = -W'(ra);
            mul_once(ra, '1, rp, "R8");
        end

        // R2: back-to-back strobes give consecutive products.
        @(negedge clk);
        a_in = 16'd3; b_in = 16'd5; in_valid = 1'b1;
        @(negedge clk);
        check("R1", product, 32'd15);
        a_in = 16'hFFFD; b_in = 16'd7;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", product, 32'hFFFFFFEB);
        check("R2", {{(W-1){1'b0}}, out_valid}, 1);

        // R4: reset in the middle of operation clears the held product.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R4", product, '0);
        check("R4", {{(W-1){1'b0}}, out_valid}, 0);
        rst_n = 1'b1;
        mul_once(16'h8000, 16'h8000, 32'h40000000, "R5");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule